// File: doc/BRIEF.md
# Multiplexed LCD Common/Segment Sequencer

This block sequences the drive levels of a time-multiplexed liquid-crystal panel. It has three common lines and 62 segment lines. A 186-bit display image arrives as a parallel input vector. The block walks a common phase counter through the active commons. For each common and segment it emits a 2-bit drive-level code, which an analog stage turns into supply, upper bias, lower bias or ground. The selected common swings to a full-scale level. The unselected commons sit at a bias level. The polarity inverts on every frame, so the panel sees no DC component.

A duty input selects two or three active commons. In master mode, the common clock comes from the oscillator tick divided by four. The block drives this clock out together with a frame-start sync. In slave mode, it takes the same clock and sync from a master, so several devices share one phase and one polarity. Two active-low override inputs force every segment off (blank) or on (lamp test).

Top module: `lcd_mux_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, every level code is 2'b00, and `cclk_out` and `sync_out` are low. Reset leaves the phase at 2 and the polarity at 1, so the first step enters phase 0 with polarity 0.
- R2: In master mode, `cclk_out` is the oscillator tick divided by four. A 2-bit tick count (reset 0) advances on each `osc_tick`. `cclk_out` is high when that count is 2 or 3. It therefore rises on the second tick after reset, and again on every fourth tick after that.
- R3: The phase advances by one at each rise of the common clock. Common `k` is selected when the phase equals `k`. The on/off state of segment `n` comes from `latch_bits[k*62+n]`. Common `k` occupies `com_lvl[2k+1:2k]`, and segment `n` occupies `seg_lvl[2n+1:2n]`.
- R4: The level codes are 11 = supply, 10 = upper bias, 01 = lower bias, 00 = ground. With polarity 0: the selected common is 11, unselected commons are 01, an on segment is 00 and an off segment is 10. Polarity 1 uses 00, 10, 11 and 01 in the same order. The polarity toggles each time the phase enters 0.
- R5: With `duty_two` high, the phase counts 0, 1, 0, and so on. Any phase at or beyond the last active common returns to 0 on the next step.
- R6: In master mode, `sync_out` is high exactly while the phase is 0. It rises in the same clock cycle as `cclk_out`.
- R7: In slave mode (`is_master` low), `cclk_out` and `sync_out` are held low and `osc_tick` is ignored. The phase steps one clock after each rising edge of `ext_cclk`. If `sync_in` is high at that step, the phase goes to 0 instead.
- R8: With `lamp_n` low and `blank_n` high, every segment carries the on level.
- R9: With `blank_n` low, every segment carries the off level, whatever `lamp_n` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| is_master | input | 1 | 1 = master timing, 0 = slave timing |
| duty_two | input | 1 | 1 = two active commons, 0 = three |
| osc_tick | input | 1 | One-cycle pulse at the oscillator rate |
| ext_cclk | input | 1 | Common clock from a master (slave mode) |
| sync_in | input | 1 | Frame sync from a master (slave mode) |
| blank_n | input | 1 | Active-low force of all segments off |
| lamp_n | input | 1 | Active-low force of all segments on |
| latch_bits | input | 186 | Display image, bit k*62+n for common k, segment n |
| cclk_out | output | 1 | Common clock to slaves |
| sync_out | output | 1 | Frame sync to slaves |
| com_lvl | output | 6 | Level codes of the three commons |
| seg_lvl | output | 124 | Level codes of the 62 segments |

## Verification
Blank and lamp test can be active in the same cycle, and their conflict is settled by a fixed priority. The bench pulls both low while a frame with mixed segment data is shown. It expects every segment at the off level for the current polarity. It then releases lamp test alone and expects the same result. A second coincidence is the master's phase wrap: the sync rise, the clock rise and the polarity flip land on one edge. The scoreboard checks all three in a single comparison.

// File: rtl/lcd_mux_pkg.sv
package lcd_mux_pkg;
  typedef enum logic [1:0] {
    LV_GND = 2'b00,
    LV_LO  = 2'b01,
    LV_HI  = 2'b10,
    LV_SUP = 2'b11
  } lvl_t;
endpackage

// File: rtl/lcd_timebase.sv
module lcd_timebase #(
  parameter int NCOM = 3,
  parameter int DIVW = 2,
  localparam int PW = (NCOM > 1) ? $clog2(NCOM) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          is_master,
  input  logic          duty_two,
  input  logic          osc_tick,
  input  logic          ext_cclk,
  input  logic          sync_in,
  output logic [PW-1:0] phase_q,
  output logic          pol_q,
  output logic          cclk_out,
  output logic          sync_out
);
  localparam int HALF = 1 << (DIVW - 1);

  logic [DIVW-1:0] div_q, div_d;
  logic            ext_q;
  logic            m_tick, s_tick, step;
  logic [PW-1:0]   last, phase_d;
  logic            pol_d;

  always_comb begin
    div_d = div_q;
    if (is_master && osc_tick) div_d = div_q + 1'b1;
    m_tick = is_master && osc_tick && (div_q == DIVW'(HALF - 1));
    s_tick = !is_master && ext_cclk && !ext_q;
    step   = m_tick || s_tick;
    last   = duty_two ? PW'(NCOM - 2) : PW'(NCOM - 1);
    phase_d = phase_q;
    if (s_tick && sync_in)
      phase_d = '0;
    else if (step)
      phase_d = (phase_q >= last) ? '0 : PW'(phase_q + 1'b1);
    pol_d = pol_q;
    if (step && (phase_d == '0)) pol_d = ~pol_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q    <= '0;
      ext_q    <= 1'b0;
      phase_q  <= PW'(NCOM - 1);
      pol_q    <= 1'b1;
      cclk_out <= 1'b0;
      sync_out <= 1'b0;
    end else begin
      div_q    <= div_d;
      ext_q    <= ext_cclk;
      phase_q  <= phase_d;
      pol_q    <= pol_d;
      cclk_out <= is_master && div_d[DIVW-1];
      sync_out <= is_master && (phase_d == '0);
    end
  end
endmodule

// File: rtl/lcd_com_drive.sv
module lcd_com_drive
  import lcd_mux_pkg::*;
#(
  parameter int NCOM = 3,
  localparam int PW = (NCOM > 1) ? $clog2(NCOM) : 1
) (
  input  logic [PW-1:0]     phase,
  input  logic              pol,
  output logic [2*NCOM-1:0] com_d
);
  for (genvar k = 0; k < NCOM; k++) begin : g_com
    lvl_t sel_lv, idle_lv;
    assign sel_lv  = pol ? LV_GND : LV_SUP;
    assign idle_lv = pol ? LV_HI : LV_LO;
    assign com_d[2*k +: 2] = (phase == PW'(k)) ? sel_lv : idle_lv;
  end
endmodule

// File: rtl/lcd_seg_drive.sv
module lcd_seg_drive
  import lcd_mux_pkg::*;
#(
  parameter int NCOM = 3,
  parameter int NSEG = 62,
  localparam int PW = (NCOM > 1) ? $clog2(NCOM) : 1
) (
  input  logic [NCOM*NSEG-1:0] latch_bits,
  input  logic [PW-1:0]        phase,
  input  logic                 pol,
  input  logic                 blank_n,
  input  logic                 lamp_n,
  output logic [2*NSEG-1:0]    seg_d
);
  logic [NSEG-1:0] row;

  always_comb begin
    row = '0;
    for (int k = 0; k < NCOM; k++)
      if (phase == PW'(k)) row = latch_bits[k*NSEG +: NSEG];
  end

  for (genvar n = 0; n < NSEG; n++) begin : g_seg
    logic on;
    lvl_t on_lv, off_lv;
    assign on     = !blank_n ? 1'b0 : (!lamp_n ? 1'b1 : row[n]);
    assign on_lv  = pol ? LV_SUP : LV_GND;
    assign off_lv = pol ? LV_LO : LV_HI;
    assign seg_d[2*n +: 2] = on ? on_lv : off_lv;
  end
endmodule

// File: rtl/lcd_mux_seq.sv
module lcd_mux_seq #(
  parameter int NCOM = 3,
  parameter int NSEG = 62,
  parameter int DIVW = 2,
  localparam int PW = (NCOM > 1) ? $clog2(NCOM) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 is_master,
  input  logic                 duty_two,
  input  logic                 osc_tick,
  input  logic                 ext_cclk,
  input  logic                 sync_in,
  input  logic                 blank_n,
  input  logic                 lamp_n,
  input  logic [NCOM*NSEG-1:0] latch_bits,
  output logic                 cclk_out,
  output logic                 sync_out,
  output logic [2*NCOM-1:0]    com_lvl,
  output logic [2*NSEG-1:0]    seg_lvl
);
  logic [PW-1:0]     phase;
  logic              pol;
  logic [2*NCOM-1:0] com_d;
  logic [2*NSEG-1:0] seg_d;

  lcd_timebase #(.NCOM(NCOM), .DIVW(DIVW)) tb_i (
    .clk(clk), .rst(rst), .is_master(is_master), .duty_two(duty_two),
    .osc_tick(osc_tick), .ext_cclk(ext_cclk), .sync_in(sync_in),
    .phase_q(phase), .pol_q(pol), .cclk_out(cclk_out), .sync_out(sync_out)
  );

  lcd_com_drive #(.NCOM(NCOM)) com_i (
    .phase(phase), .pol(pol), .com_d(com_d)
  );

  lcd_seg_drive #(.NCOM(NCOM), .NSEG(NSEG)) seg_i (
    .latch_bits(latch_bits), .phase(phase), .pol(pol),
    .blank_n(blank_n), .lamp_n(lamp_n), .seg_d(seg_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      com_lvl <= '0;
      seg_lvl <= '0;
    end else begin
      com_lvl <= com_d;
      seg_lvl <= seg_d;
    end
  end
endmodule

// File: rtl/lcd_mux_seq_chk.sv
module lcd_mux_seq_chk #(
  parameter int NCOM = 3,
  parameter int NSEG = 62
) (
  input logic              clk,
  input logic              rst,
  input logic              is_master,
  input logic              blank_n,
  input logic              lamp_n,
  input logic              cclk_out,
  input logic              sync_out,
  input logic [2*NCOM-1:0] com_lvl,
  input logic [2*NSEG-1:0] seg_lvl
);
  logic [NCOM-1:0] com_ext;
  logic [NSEG-1:0] seg_ext;

  always_comb begin
    for (int k = 0; k < NCOM; k++) com_ext[k] = (com_lvl[2*k] == com_lvl[2*k+1]);
    for (int n = 0; n < NSEG; n++) seg_ext[n] = (seg_lvl[2*n] == seg_lvl[2*n+1]);
  end

  assert_one_selected_R3: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ($countones(com_ext) == 1));

  assert_lamp_all_on_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(blank_n) && $past(!lamp_n)) |-> (&seg_ext));

  assert_blank_all_off_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!blank_n)) |-> (seg_ext == '0));

  assert_sync_with_clock_R6: assert property (@(posedge clk) disable iff (rst)
    (is_master && $past(is_master) && $past(is_master, 2) && $rose(sync_out))
      |-> $rose(cclk_out));

  assert_slave_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !is_master |=> (!cclk_out && !sync_out));
endmodule

bind lcd_mux_seq lcd_mux_seq_chk #(.NCOM(NCOM), .NSEG(NSEG)) chk_i (
  .clk(clk), .rst(rst), .is_master(is_master), .blank_n(blank_n),
  .lamp_n(lamp_n), .cclk_out(cclk_out), .sync_out(sync_out),
  .com_lvl(com_lvl), .seg_lvl(seg_lvl)
);

// File: tb/lcd_mux_seq_tb_top.sv
module lcd_mux_seq_tb_top;
  localparam int NCOM = 3;
  localparam int NSEG = 62;

  typedef struct {
    string             tag;
    int                due;
    logic [2*NCOM-1:0] com;
    logic [2*NSEG-1:0] seg;
    logic              cclk;
    logic              sync;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic is_master = 1'b1, duty_two = 1'b0, osc_tick = 1'b0;
  logic ext_cclk = 1'b0, sync_in = 1'b0, blank_n = 1'b1, lamp_n = 1'b1;
  logic [NCOM*NSEG-1:0] latch_bits = '0;
  logic cclk_out, sync_out;
  logic [2*NCOM-1:0] com_lvl;
  logic [2*NSEG-1:0] seg_lvl;

  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;
  item_t sb[$];

  int m_div = 0, m_phase = 2;
  bit m_pol = 1;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lcd_mux_seq #(.NCOM(NCOM), .NSEG(NSEG)) dut_i (
    .clk(clk), .rst(rst), .is_master(is_master), .duty_two(duty_two),
    .osc_tick(osc_tick), .ext_cclk(ext_cclk), .sync_in(sync_in),
    .blank_n(blank_n), .lamp_n(lamp_n), .latch_bits(latch_bits),
    .cclk_out(cclk_out), .sync_out(sync_out), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );

  function automatic int last_ph();
    return duty_two ? NCOM - 2 : NCOM - 1;
  endfunction

  function automatic void step_phase(bit to_zero);
    if (to_zero || m_phase >= last_ph()) m_phase = 0;
    else m_phase = m_phase + 1;
    if (m_phase == 0) m_pol = ~m_pol;
  endfunction

  task automatic osc_pulse();
    @(negedge clk) osc_tick = 1'b1;
    @(negedge clk) osc_tick = 1'b0;
    if (is_master) begin
      if (m_div == 1) step_phase(1'b0);
      m_div = (m_div + 1) % 4;
    end
  endtask

  task automatic osc4();
    repeat (4) osc_pulse();
  endtask

  task automatic ext_rise(bit s);
    @(negedge clk) begin ext_cclk = 1'b1; sync_in = s; end
    @(negedge clk);
    @(negedge clk) ext_cclk = 1'b0;
    @(negedge clk) sync_in = 1'b0;
    step_phase(s);
  endtask

  // Driver: compute expected outputs from the requirements and queue them
  task automatic expect_now(string tag);
    item_t it;
    it.tag = tag;
    it.due = cyc + 3;
    for (int k = 0; k < NCOM; k++)
      if (k == m_phase) it.com[2*k +: 2] = m_pol ? 2'b00 : 2'b11;
      else              it.com[2*k +: 2] = m_pol ? 2'b10 : 2'b01;
    for (int n = 0; n < NSEG; n++) begin
      bit on;
      on = !blank_n ? 1'b0 : (!lamp_n ? 1'b1 : latch_bits[m_phase*NSEG + n]);
      if (on) it.seg[2*n +: 2] = m_pol ? 2'b11 : 2'b00;
      else    it.seg[2*n +: 2] = m_pol ? 2'b01 : 2'b10;
    end
    it.cclk = is_master && (m_div >= 2);
    it.sync = is_master && (m_phase == 0);
    sb.push_back(it);
    repeat (4) @(negedge clk);
  endtask

  // Monitor: pop and compare when the item falls due
  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].due == cyc) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (com_lvl !== it.com || seg_lvl !== it.seg ||
          cclk_out !== it.cclk || sync_out !== it.sync) begin
        errors++;
        $display("FAIL %s: com=%h exp %h seg=%h exp %h cclk=%b exp %b sync=%b exp %b",
                 it.tag, com_lvl, it.com, seg_lvl, it.seg, cclk_out, it.cclk,
                 sync_out, it.sync);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCOM*NSEG; i++) latch_bits[i] = (((i*5 + 1) % 7) < 3);
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    checks++;
    if (com_lvl !== '0 || seg_lvl !== '0 || cclk_out !== 1'b0 || sync_out !== 1'b0) begin
      errors++;
      $display("FAIL R1: com=%h seg=%h cclk=%b sync=%b expected all zero",
               com_lvl, seg_lvl, cclk_out, sync_out);
    end
    rst = 1'b0;
    expect_now("R1 post-reset phase2 pol1");
    osc_pulse();  expect_now("R2 one tick, clock still low");
    osc_pulse();  expect_now("R6 wrap: clock, sync and polarity together");
    osc_pulse();  expect_now("R2 clock high second tick");
    osc_pulse();  expect_now("R2 clock low again");
    osc4();       expect_now("R3 phase 1");
    osc4();       expect_now("R3 phase 2");
    osc4();       expect_now("R4 phase 0 inverted polarity");
    for (int i = 0; i < NCOM*NSEG; i++) latch_bits[i] = ((i % 3) == 1) ^ (i > 100);
    expect_now("R3 new image");
    lamp_n = 1'b0;  expect_now("R8 lamp test");
    blank_n = 1'b0; expect_now("R9 blank with lamp test");
    lamp_n = 1'b1;  expect_now("R9 blank alone");
    blank_n = 1'b1;
    duty_two = 1'b1;
    osc4(); expect_now("R5 two-common phase 1");
    osc4(); expect_now("R5 two-common wrap");
    osc4(); expect_now("R5 two-common phase 1 again");
    duty_two = 1'b0;
    is_master = 1'b0; expect_now("R7 slave outputs quiet");
    osc4();            expect_now("R7 osc ignored in slave");
    ext_rise(1'b0);    expect_now("R7 slave step");
    ext_rise(1'b1);    expect_now("R7 slave sync to phase 0");
    ext_rise(1'b0);    expect_now("R7 slave step after sync");
    repeat (4) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule